// File: doc/BRIEF.md
# Indexed Effective Address Sequencer

This block produces the bus cycle sequence and the final effective address for the four indexed addressing forms of an 8-bit processor core. It takes over once the opcode and its operand bytes have been fetched. A one-cycle `start` pulse, given while the block is idle, supplies the addressing form, the access class, both index registers and the operand bytes. From the next cycle on, the block presents one bus access per cycle and marks each one as a read or a write. It also flags the accesses whose data the core throws away, and raises `done` on the access that carries the instruction's real data. The ALU and the write data are outside the block: the core supplies the data and consumes `rd_data` on the cycles it needs.

The addressing forms are zero-page indexed, absolute indexed, pre-indexed indirect (pointer plus X) and post-indexed indirect (pointer, then plus Y). Zero-page pointer arithmetic always wraps inside page zero. When an index is added to a 16-bit base, only the low byte is added at first. One access is then made at the uncorrected address. For reads, the corrected access follows only when the add carried. For writes and read-modify-writes, the corrected access always follows.

The control states are S_IDLE, S_ZP_BASE, S_PTR_BASE, S_PTR_LO, S_PTR_HI, S_UNFIX, S_DATA_RD, S_WBACK and S_DATA_WR. The transitions are:
- S_IDLE goes on `start` to S_ZP_BASE (zero page), S_UNFIX (absolute), S_PTR_BASE (pre-indexed) or S_PTR_LO (post-indexed).
- S_PTR_BASE goes to S_PTR_LO, and S_PTR_LO goes to S_PTR_HI.
- S_PTR_HI goes to S_UNFIX for post-indexed. For pre-indexed it takes the data step.
- S_ZP_BASE takes the data step.
- The data step goes to S_DATA_WR for writes and to S_DATA_RD otherwise.
- S_UNFIX goes to S_IDLE for a read without carry. Otherwise it takes the data step.
- S_DATA_RD goes to S_IDLE for reads and to S_WBACK for read-modify-writes.
- S_WBACK goes to S_DATA_WR, and S_DATA_WR goes to S_IDLE.

Top module: `idx_seq`

## Requirements
- R1: After reset, `busy`, `bus_act`, `bus_wr`, `bus_dummy` and `done` are 0.
- R2: `start` is taken only in the idle state; first access the cycle after. While busy, `start` and all operand inputs are ignored, and the running sequence is unchanged.
- R3: Zero-page indexed (`mode`=0). The first access is a dummy read at {0x00, base}. The data access follows at {0x00, base+index mod 256}. The index is X, or Y when `sel_y`=1.
- R4: Absolute indexed read (`mode`=1, `cls`=0 or 3). The first access is a read at {hi, (lo+index) mod 256}. It is final if the low add did not carry. On a carry it is a dummy, and a read at the corrected address follows.
- R5: Absolute indexed write (`cls`=2). A dummy read at the uncorrected address always comes first. The write at the corrected address follows.
- R6: Read-modify-write (`cls`=1). The block reads the target, then does a dummy write at the same address, then does the final write there. In absolute and post-indexed forms, the uncorrected dummy read always comes first.
- R7: Pre-indexed (`mode`=2). The steps are a dummy read at {0x00, ptr}, then reads at {0x00, ptr+X} and {0x00, ptr+X+1}, both mod 256. These two reads give the low and high target bytes, and the data access follows at that target.
- R8: Post-indexed (`mode`=3). The block reads {0x00, ptr} and {0x00, ptr+1 mod 256} to get the base, adds Y to its low byte, and continues as in R4 to R6.
- R9: `done` is high for exactly the final data access. `busy` is 0 in the cycle after it.
- R10: During the final access, `eff_addr` equals `bus_addr`. It keeps that value while idle, until the next accepted `start`.
- R11: A carry out of the low-byte add increments the high byte mod 256, so 0xFF becomes 0x00.
- R12: `bus_dummy` is 1 on exactly these accesses: the base and pointer dummy reads, the uncorrected read when it is not final, and the write-back of an unmodified value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sequence (taken when idle) |
| mode | input | 2 | 0 zero-page idx, 1 absolute idx, 2 pre-indexed X, 3 post-indexed Y |
| cls | input | 2 | 0 read, 1 read-modify-write, 2 write, 3 read |
| sel_y | input | 1 | Use Y instead of X for modes 0 and 1 |
| x_idx | input | 8 | X index |
| y_idx | input | 8 | Y index |
| opnd_lo | input | 8 | First operand byte (base low or pointer) |
| opnd_hi | input | 8 | Second operand byte (base high, mode 1) |
| rd_data | input | 8 | Read data for the current access |
| busy | output | 1 | Sequence in progress |
| bus_act | output | 1 | A bus access is made this cycle |
| bus_addr | output | 16 | Access address |
| bus_wr | output | 1 | 1 write, 0 read |
| bus_dummy | output | 1 | Access data is discarded |
| done | output | 1 | Final data access this cycle |
| eff_addr | output | 16 | Corrected effective address |

## Verification
Every addressing form is run with every class and with both index selections, over operand and index sets. The sets include no carry, a low-byte carry, a carry out of high byte 0xFF, and pointers at 0xFF that wrap into 0x00. A carry on a read tells apart the four-step and five-step absolute paths. Writes and read-modify-writes without a carry show that the uncorrected access is still made. The target bytes come from an address-derived memory function, so a wrong pointer address shows up as a wrong target. Some runs toggle `start` and change the operands mid-sequence to show that they are ignored.

// File: rtl/idx_seq_pkg.sv
package idx_seq_pkg;

    typedef enum logic [1:0] {
        AM_ZPI   = 2'd0,
        AM_ABSI  = 2'd1,
        AM_PREX  = 2'd2,
        AM_POSTY = 2'd3
    } amode_e;

    typedef enum logic [1:0] {
        AC_READ  = 2'd0,
        AC_RMW   = 2'd1,
        AC_WRITE = 2'd2,
        AC_READ2 = 2'd3
    } aclass_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ZP_BASE,
        S_PTR_BASE,
        S_PTR_LO,
        S_PTR_HI,
        S_UNFIX,
        S_DATA_RD,
        S_WBACK,
        S_DATA_WR
    } state_e;

    typedef enum logic [2:0] {
        A_NONE,
        A_PTR,
        A_PTR1,
        A_RAW,
        A_EA
    } asel_e;

endpackage

// File: rtl/idx_seq_add.sv
module idx_seq_add #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0] wide;
    assign wide = {1'b0, a} + {1'b0, b};
    assign sum  = wide[W-1:0];
    assign cout = wide[W];
endmodule

// File: rtl/idx_seq_ctrl.sv
module idx_seq_ctrl
    import idx_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    input  amode_e  mode_i,
    input  aclass_e cls_i,
    input  logic    cry,
    output logic    accept,
    output logic    busy,
    output logic    bus_act,
    output logic    bus_wr,
    output logic    bus_dummy,
    output logic    done,
    output asel_e   asel,
    output logic    ptr_add,
    output logic    ld_lo,
    output logic    ld_hi,
    output logic    fold_y
);
    state_e  st, st_nx;
    amode_e  mode_q;
    aclass_e cls_q;
    logic    is_rd, is_wr, rd_final;
    state_e  data_step;

    assign is_rd     = (cls_q == AC_READ) || (cls_q == AC_READ2);
    assign is_wr     = (cls_q == AC_WRITE);
    assign rd_final  = is_rd && !cry;
    assign data_step = is_wr ? S_DATA_WR : S_DATA_RD;
    assign accept    = (st == S_IDLE) && start;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= S_IDLE;
            mode_q <= AM_ZPI;
            cls_q  <= AC_READ;
        end else begin
            st <= st_nx;
            if (accept) begin
                mode_q <= mode_i;
                cls_q  <= cls_i;
            end
        end
    end

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE: begin
                if (start) begin
                    unique case (mode_i)
                        AM_ZPI:   st_nx = S_ZP_BASE;
                        AM_ABSI:  st_nx = S_UNFIX;
                        AM_PREX:  st_nx = S_PTR_BASE;
                        AM_POSTY: st_nx = S_PTR_LO;
                        default:  st_nx = S_IDLE;
                    endcase
                end
            end
            S_ZP_BASE:  st_nx = data_step;
            S_PTR_BASE: st_nx = S_PTR_LO;
            S_PTR_LO:   st_nx = S_PTR_HI;
            S_PTR_HI:   st_nx = (mode_q == AM_PREX) ? data_step : S_UNFIX;
            S_UNFIX:    st_nx = rd_final ? S_IDLE : data_step;
            S_DATA_RD:  st_nx = is_rd ? S_IDLE : S_WBACK;
            S_WBACK:    st_nx = S_DATA_WR;
            S_DATA_WR:  st_nx = S_IDLE;
            default:    st_nx = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy      = (st != S_IDLE);
        bus_act   = 1'b0;
        bus_wr    = 1'b0;
        bus_dummy = 1'b0;
        done      = 1'b0;
        asel      = A_NONE;
        ptr_add   = 1'b0;
        ld_lo     = 1'b0;
        ld_hi     = 1'b0;
        fold_y    = 1'b0;
        unique case (st)
            S_IDLE: ;
            S_ZP_BASE: begin
                bus_act   = 1'b1;
                bus_dummy = 1'b1;
                asel      = A_PTR;
            end
            S_PTR_BASE: begin
                bus_act   = 1'b1;
                bus_dummy = 1'b1;
                asel      = A_PTR;
                ptr_add   = 1'b1;
            end
            S_PTR_LO: begin
                bus_act = 1'b1;
                asel    = A_PTR;
                ld_lo   = 1'b1;
            end
            S_PTR_HI: begin
                bus_act = 1'b1;
                asel    = A_PTR1;
                ld_hi   = 1'b1;
                fold_y  = (mode_q == AM_POSTY);
            end
            S_UNFIX: begin
                bus_act   = 1'b1;
                asel      = A_RAW;
                bus_dummy = !rd_final;
                done      = rd_final;
            end
            S_DATA_RD: begin
                bus_act = 1'b1;
                asel    = A_EA;
                done    = is_rd;
            end
            S_WBACK: begin
                bus_act   = 1'b1;
                bus_wr    = 1'b1;
                bus_dummy = 1'b1;
                asel      = A_EA;
            end
            S_DATA_WR: begin
                bus_act = 1'b1;
                bus_wr  = 1'b1;
                done    = 1'b1;
                asel    = A_EA;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/idx_seq_dp.sv
module idx_seq_dp
    import idx_seq_pkg::*;
#(
    parameter int DW = 8,
    localparam int AW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  amode_e        mode_i,
    input  logic          sel_y,
    input  logic [DW-1:0] x_idx,
    input  logic [DW-1:0] y_idx,
    input  logic [DW-1:0] opnd_lo,
    input  logic [DW-1:0] opnd_hi,
    input  logic [DW-1:0] rd_data,
    input  asel_e         asel,
    input  logic          ptr_add,
    input  logic          ld_lo,
    input  logic          ld_hi,
    input  logic          fold_y,
    output logic          cry,
    output logic [AW-1:0] bus_addr,
    output logic [AW-1:0] eff_addr
);
    logic [DW-1:0] ptr_q, idx_q, lo_q, hi_q;
    logic          cry_q;
    logic [DW-1:0] idx_new, s0, s1, a1, ptr_inc, hi_fix;
    logic          c0, c1;

    always_comb begin
        unique case (mode_i)
            AM_PREX:  idx_new = x_idx;
            AM_POSTY: idx_new = y_idx;
            default:  idx_new = sel_y ? y_idx : x_idx;
        endcase
    end

    assign a1      = ptr_add ? ptr_q : lo_q;
    assign ptr_inc = ptr_q + DW'(1);
    assign hi_fix  = hi_q + DW'(cry_q);

    idx_seq_add #(.W(DW)) u_add_start (.a(opnd_lo), .b(idx_new), .sum(s0), .cout(c0));
    idx_seq_add #(.W(DW)) u_add_run   (.a(a1),      .b(idx_q),   .sum(s1), .cout(c1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            idx_q <= '0;
            lo_q  <= '0;
            hi_q  <= '0;
            cry_q <= 1'b0;
        end else if (accept) begin
            idx_q <= idx_new;
            ptr_q <= opnd_lo;
            unique case (mode_i)
                AM_ZPI: begin
                    lo_q  <= s0;
                    hi_q  <= '0;
                    cry_q <= 1'b0;
                end
                AM_ABSI: begin
                    lo_q  <= s0;
                    hi_q  <= opnd_hi;
                    cry_q <= c0;
                end
                default: begin
                    lo_q  <= '0;
                    hi_q  <= '0;
                    cry_q <= 1'b0;
                end
            endcase
        end else begin
            if (ptr_add) ptr_q <= s1;
            if (ld_lo)   lo_q  <= rd_data;
            if (ld_hi) begin
                hi_q <= rd_data;
                if (fold_y) begin
                    lo_q  <= s1;
                    cry_q <= c1;
                end
            end
        end
    end

    always_comb begin
        unique case (asel)
            A_PTR:   bus_addr = {{DW{1'b0}}, ptr_q};
            A_PTR1:  bus_addr = {{DW{1'b0}}, ptr_inc};
            A_RAW:   bus_addr = {hi_q, lo_q};
            A_EA:    bus_addr = {hi_fix, lo_q};
            default: bus_addr = '0;
        endcase
    end

    assign eff_addr = {hi_fix, lo_q};
    assign cry      = cry_q;
endmodule

// File: rtl/idx_seq.sv
module idx_seq
    import idx_seq_pkg::*;
#(
    parameter int DW = 8,
    localparam int AW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    mode,
    input  logic [1:0]    cls,
    input  logic          sel_y,
    input  logic [DW-1:0] x_idx,
    input  logic [DW-1:0] y_idx,
    input  logic [DW-1:0] opnd_lo,
    input  logic [DW-1:0] opnd_hi,
    input  logic [DW-1:0] rd_data,
    output logic          busy,
    output logic          bus_act,
    output logic [AW-1:0] bus_addr,
    output logic          bus_wr,
    output logic          bus_dummy,
    output logic          done,
    output logic [AW-1:0] eff_addr
);
    amode_e  mode_e;
    aclass_e cls_e;
    asel_e   asel;
    logic    accept, cry, ptr_add, ld_lo, ld_hi, fold_y;

    assign mode_e = amode_e'(mode);
    assign cls_e  = aclass_e'(cls);

    idx_seq_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_i(mode_e), .cls_i(cls_e),
        .cry(cry), .accept(accept), .busy(busy), .bus_act(bus_act),
        .bus_wr(bus_wr), .bus_dummy(bus_dummy), .done(done), .asel(asel),
        .ptr_add(ptr_add), .ld_lo(ld_lo), .ld_hi(ld_hi), .fold_y(fold_y)
    );

    idx_seq_dp #(.DW(DW)) u_dp (
        .clk(clk), .rst_n(rst_n), .accept(accept), .mode_i(mode_e),
        .sel_y(sel_y), .x_idx(x_idx), .y_idx(y_idx), .opnd_lo(opnd_lo),
        .opnd_hi(opnd_hi), .rd_data(rd_data), .asel(asel), .ptr_add(ptr_add),
        .ld_lo(ld_lo), .ld_hi(ld_hi), .fold_y(fold_y), .cry(cry),
        .bus_addr(bus_addr), .eff_addr(eff_addr)
    );
endmodule

// File: rtl/idx_seq_chk.sv
module idx_seq_chk #(
    parameter int DW = 8,
    localparam int AW = 2 * DW
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [1:0]    mode,
    input logic          busy,
    input logic          bus_act,
    input logic [AW-1:0] bus_addr,
    input logic          bus_wr,
    input logic          bus_dummy,
    input logic          done,
    input logic [AW-1:0] eff_addr
);
    logic zp_run;

    always_ff @(posedge clk) begin
        if (!rst_n)               zp_run <= 1'b0;
        else if (start && !busy)  zp_run <= (mode == 2'd0);
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !busy && !bus_act && !done);

    a_r2_start_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy && bus_act);

    a_r3_zp_page: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && zp_run) |-> (bus_addr[AW-1:DW] == '0));

    a_r6_wback_then_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_dummy) |=> (bus_wr && !bus_dummy && done
                                   && bus_addr == $past(bus_addr)));

    a_r9_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    a_r9_fall_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));

    a_r10_final_at_ea: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> bus_act && !bus_dummy && (bus_addr == eff_addr));

    a_r10_ea_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(eff_addr));

    a_r12_dummy_is_access: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_dummy || bus_wr) |-> bus_act);
endmodule

bind idx_seq idx_seq_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .busy(busy),
    .bus_act(bus_act), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_dummy(bus_dummy), .done(done), .eff_addr(eff_addr)
);

// File: tb/test_idx_seq.sv
`timescale 1ns/1ps
module test_idx_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  mode = '0;
    logic [1:0]  cls = '0;
    logic        sel_y = 1'b0;
    logic [7:0]  x_idx = '0, y_idx = '0, opnd_lo = '0, opnd_hi = '0;
    logic [7:0]  rd_data;
    logic        busy, bus_act, bus_wr, bus_dummy, done;
    logic [15:0] bus_addr, eff_addr;

    int checks = 0;
    int errors = 0;

    logic [15:0] e_addr [8];
    logic        e_wr   [8];
    logic        e_dm   [8];
    int          n;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] mem_f(input logic [15:0] a);
        return a[7:0] ^ {a[14:8], a[15]} ^ 8'h5A;
    endfunction

    always_comb rd_data = mem_f(bus_addr);

    idx_seq i_idx_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .cls(cls),
        .sel_y(sel_y), .x_idx(x_idx), .y_idx(y_idx), .opnd_lo(opnd_lo),
        .opnd_hi(opnd_hi), .rd_data(rd_data), .busy(busy), .bus_act(bus_act),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_dummy(bus_dummy),
        .done(done), .eff_addr(eff_addr)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [15:0] a, input logic w, input logic d);
        e_addr[n] = a; e_wr[n] = w; e_dm[n] = d; n++;
    endtask

    task automatic run(input logic [1:0] m, input logic [1:0] c, input logic sy,
                       input logic [7:0] x, input logic [7:0] y,
                       input logic [7:0] lo, input logic [7:0] hi, input logic poke);
        logic [7:0]  idx, p, q, blo, bhi, h;
        logic [8:0]  s;
        logic [15:0] unc, eaf;
        logic        rd;
        string       tag;
        rd  = (c == 2'd0) || (c == 2'd3);
        idx = sy ? y : x;
        n   = 0;
        unc = '0;
        s   = '0;
        case (m)
            2'd0: begin
                tag = "R3";
                push({8'h00, lo}, 1'b0, 1'b1);
                p   = lo + idx;
                eaf = {8'h00, p};
            end
            2'd1: begin
                tag = (c == 2'd1) ? "R6" : (c == 2'd2) ? "R5" : "R4";
                s   = {1'b0, lo} + {1'b0, idx};
                h   = hi + {7'b0, s[8]};
                unc = {hi, s[7:0]};
                eaf = {h, s[7:0]};
            end
            2'd2: begin
                tag = (c == 2'd1) ? "R7 R6" : "R7";
                push({8'h00, lo}, 1'b0, 1'b1);
                p = lo + x;
                q = p + 8'd1;
                push({8'h00, p}, 1'b0, 1'b0);
                push({8'h00, q}, 1'b0, 1'b0);
                eaf = {mem_f({8'h00, q}), mem_f({8'h00, p})};
            end
            default: begin
                tag = (c == 2'd1) ? "R8 R6" : "R8";
                p = lo + 8'd1;
                push({8'h00, lo}, 1'b0, 1'b0);
                push({8'h00, p}, 1'b0, 1'b0);
                blo = mem_f({8'h00, lo});
                bhi = mem_f({8'h00, p});
                s   = {1'b0, blo} + {1'b0, y};
                h   = bhi + {7'b0, s[8]};
                unc = {bhi, s[7:0]};
                eaf = {h, s[7:0]};
            end
        endcase
        if (m[0]) begin
            if (rd && !s[8]) push(unc, 1'b0, 1'b0);
            else             push(unc, 1'b0, 1'b1);
            if (s[8] && unc[15:8] == 8'hFF) tag = {tag, " R11"};
        end
        if (c == 2'd2) push(eaf, 1'b1, 1'b0);
        else if (c == 2'd1) begin
            push(eaf, 1'b0, 1'b0);
            push(eaf, 1'b1, 1'b1);
            push(eaf, 1'b1, 1'b0);
        end else if (!(m[0] && !s[8])) push(eaf, 1'b0, 1'b0);
        if (poke) tag = {tag, " R2"};

        @(negedge clk);
        start = 1'b1; mode = m; cls = c; sel_y = sy;
        x_idx = x; y_idx = y; opnd_lo = lo; opnd_hi = hi;
        @(negedge clk);
        for (int i = 0; i < n; i++) begin
            check({tag, " R12 R9 cycle"},
                  {43'b0, busy, bus_act, bus_wr, bus_dummy, done, bus_addr},
                  {43'b0, 1'b1, 1'b1, e_wr[i], e_dm[i], (i == n - 1), e_addr[i]});
            if (poke && i < n - 1) begin
                start = 1'b1; mode = ~m; cls = ~c; sel_y = ~sy;
                x_idx = ~x; y_idx = ~y; opnd_lo = ~lo; opnd_hi = ~hi;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        check({tag, " R9 R10 end"}, {46'b0, busy, bus_act, eff_addr},
              {46'b0, 1'b0, 1'b0, eaf});
        @(negedge clk);
        check("R10 hold", {48'b0, eff_addr}, {48'b0, eaf});
    endtask

    logic [7:0] v_lo [7] = '{8'h10, 8'hF0, 8'h80, 8'hFF, 8'h00, 8'hFE, 8'h80};
    logic [7:0] v_hi [7] = '{8'h20, 8'h12, 8'hFF, 8'h00, 8'h7F, 8'h34, 8'h55};
    logic [7:0] v_x  [7] = '{8'h03, 8'h20, 8'h90, 8'h01, 8'h00, 8'h7F, 8'h7F};
    logic [7:0] v_y  [7] = '{8'h05, 8'h01, 8'h90, 8'hFF, 8'h00, 8'hFF, 8'h01};

    initial begin
        #(5.0 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", {59'b0, busy, bus_act, bus_wr, bus_dummy, done}, 64'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle", {59'b0, busy, bus_act, bus_wr, bus_dummy, done}, 64'b0);
        for (int m = 0; m < 4; m++)
            for (int c = 0; c < 4; c++)
                for (int sy = 0; sy < 2; sy++)
                    for (int v = 0; v < 7; v++)
                        run(2'(m), 2'(c), 1'(sy), v_x[v], v_y[v], v_lo[v], v_hi[v], (v == 1));
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule